// File: doc/BRIEF.md
# Serial Delay-Value Load Controller

This block programs a two-channel programmable delay module that is reached only through four general-purpose pins. A register interface hands it two delay codes (one per channel), one hold bit per channel and a start strobe. On start it assembles a 24-bit word, sends it bit by bit on a serial data pin with a serial clock it generates itself, and then raises a separate transfer-latch clock once so that the module copies the shifted word into its delay devices. A fourth pin, output-off, follows a control bit and switches the delay outputs to high impedance when high.

The serial clock is the system clock divided by the parameter `DIV` (even, at least 2; default 8). It idles low. Data is updated only while the serial clock is low, so the receiver, which samples on the serial clock's rising edge, always sees a settled bit. `busy_o` covers one whole load and `done_o` marks its end for a single cycle. A start request that arrives during a load is dropped.

Top module: `dly_prog_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ser_data_o`, `ser_clk_o`, `xfer_clk_o`, `busy_o` and `done_o` are low and `out_off_o` is high, whatever `out_off_i` is.
- R2: One load sends 24 bits, most significant first: bit 23 is `hold_b_i`, bits 22..13 are `dly_b_i[9:0]`, bit 12 is `hold_a_i`, bits 11..2 are `dly_a_i[9:0]`, bits 1..0 are zero; the inputs are captured in the cycle `start_i` is accepted.
- R3: `ser_clk_o` is low whenever the block is idle; during a load each low phase and each high phase of it lasts exactly `DIV/2` system cycles.
- R4: `ser_data_o` changes only in a cycle where `ser_clk_o` is low, and is unchanged across every rising edge of `ser_clk_o`.
- R5: A load produces exactly 24 rising edges of `ser_clk_o`.
- R6: After the last serial bit, `xfer_clk_o` makes exactly one high pulse of `DIV/2` cycles; it rises at least `DIV/2` cycles after the final rising edge of `ser_clk_o`, and `ser_clk_o` is low while it is high.
- R7: `done_o` is high for exactly one cycle per load, in the cycle in which `xfer_clk_o` has just returned low, and `busy_o` is low in that cycle.
- R8: `busy_o` goes high in the cycle after an accepted start and stays high until the `done_o` cycle.
- R9: A start request while `busy_o` is high is ignored: the word being sent is unchanged and no extra load follows.
- R10: `out_off_o` equals `out_off_i` of the previous cycle, independent of any load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (accepted only when idle) |
| dly_a_i | input | 10 | Delay code for channel A |
| dly_b_i | input | 10 | Delay code for channel B |
| hold_a_i | input | 1 | Channel A hold bit (0 pass, 1 hold) |
| hold_b_i | input | 1 | Channel B hold bit (0 pass, 1 hold) |
| out_off_i | input | 1 | Output-off control bit |
| ser_data_o | output | 1 | Serial data pin |
| ser_clk_o | output | 1 | Serial clock pin |
| xfer_clk_o | output | 1 | Transfer-latch clock pin |
| out_off_o | output | 1 | Output-off pin (high tri-states delay outputs) |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |

## Verification
Loads are driven with all-zero and all-one words, the two alternating-bit words, and a walking pattern where channel A carries only its LSB, channel B only its MSB and the hold bits differ; the last pattern exposes swapped channels, reversed bit order or a misplaced hold bit, which symmetric words cannot. A recovered word is rebuilt at every serial-clock rise and compared with the expected frame, while clock phase widths, data stability, the latch gap and the done pulse are measured on every load. A second start issued mid-load with different inputs separates a design that restarts or re-captures from one that ignores the request.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH
  } seq_state_t;

endpackage

// File: rtl/dly_frame_pack.sv
module dly_frame_pack #(
  parameter int DLY_W   = 10,
  parameter int PAD_W   = 2,
  parameter int FRAME_W = 2 * (DLY_W + 1) + PAD_W
) (
  input  logic [DLY_W-1:0]   dly_a_i,
  input  logic [DLY_W-1:0]   dly_b_i,
  input  logic               hold_a_i,
  input  logic               hold_b_i,
  output logic [FRAME_W-1:0] frame_o
);

  localparam int CH_W = DLY_W + 1;

  // Channel B field sits at the top so it leaves first.
  assign frame_o[FRAME_W-1 -: CH_W]        = {hold_b_i, dly_b_i};
  assign frame_o[FRAME_W-1-CH_W -: CH_W]   = {hold_a_i, dly_a_i};

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_o[PAD_W-1:0] = '0;
    end
  endgenerate

endmodule

// File: rtl/dly_half_tick.sv
module dly_half_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);

  localparam int HCW = $clog2(HALF) + 1;
  localparam logic [HCW-1:0] LAST = HCW'(HALF - 1);

  logic [HCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/dly_load_seq.sv
module dly_load_seq
  import dly_prog_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  output logic               ser_data_o,
  output logic               ser_clk_o,
  output logic               xfer_clk_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  seq_state_t         st_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      sreg_q     <= '0;
      bit_q      <= '0;
      ser_data_o <= 1'b0;
      ser_clk_o  <= 1'b0;
      xfer_clk_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            sreg_q     <= frame_i << 1;
            ser_data_o <= frame_i[FRAME_W-1];
            bit_q      <= '0;
            busy_o     <= 1'b1;
            st_q       <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            ser_clk_o <= 1'b1;
            st_q      <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            ser_clk_o <= 1'b0;
            if (bit_q == LAST_BIT) begin
              ser_data_o <= 1'b0;
              st_q       <= ST_GAP;
            end else begin
              bit_q      <= bit_q + 1'b1;
              ser_data_o <= sreg_q[FRAME_W-1];
              sreg_q     <= sreg_q << 1;
              st_q       <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            xfer_clk_o <= 1'b1;
            st_q       <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (tick_i) begin
            xfer_clk_o <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b1;
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  data_stable_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk_o) |-> $stable(ser_data_o));

  // R6
  latch_clk_alone_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_clk_o |-> !ser_clk_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_after_latch_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $fell(xfer_clk_o)));

  // R3
  sclk_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk_o |-> busy_o);

  // R9
  busy_holds_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_o && !xfer_clk_o) |=> busy_o);

endmodule

// File: rtl/dly_prog_ctrl.sv
module dly_prog_ctrl #(
  parameter int DIV   = 8,
  parameter int DLY_W = 10,
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_a_i,
  input  logic [DLY_W-1:0] dly_b_i,
  input  logic             hold_a_i,
  input  logic             hold_b_i,
  input  logic             out_off_i,
  output logic             ser_data_o,
  output logic             ser_clk_o,
  output logic             xfer_clk_o,
  output logic             out_off_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int HALF    = DIV / 2;
  localparam int FRAME_W = 2 * (DLY_W + 1) + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame;
  logic               tick;

  dly_frame_pack #(
    .DLY_W   (DLY_W),
    .PAD_W   (PAD_W),
    .FRAME_W (FRAME_W)
  ) u_pack (
    .dly_a_i  (dly_a_i),
    .dly_b_i  (dly_b_i),
    .hold_a_i (hold_a_i),
    .hold_b_i (hold_b_i),
    .frame_o  (frame)
  );

  dly_half_tick #(
    .HALF (HALF)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  dly_load_seq #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .frame_i    (frame),
    .tick_i     (tick),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .xfer_clk_o (xfer_clk_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_off_o <= 1'b1;
    end else begin
      out_off_o <= out_off_i;
    end
  end

  // R10
  off_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_off_o == $past(out_off_i)));

endmodule

// File: tb/dly_prog_ctrl_bench.sv
module dly_prog_ctrl_bench;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int NBIT = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [9:0] dly_a_i = '0;
  logic [9:0] dly_b_i = '0;
  logic hold_a_i = 1'b0;
  logic hold_b_i = 1'b0;
  logic out_off_i = 1'b0;
  logic ser_data_o, ser_clk_o, xfer_clk_o, out_off_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  dly_prog_ctrl #(.DIV(DIV)) u_dly_prog_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dly_a_i(dly_a_i), .dly_b_i(dly_b_i),
    .hold_a_i(hold_a_i), .hold_b_i(hold_b_i),
    .out_off_i(out_off_i),
    .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .xfer_clk_o(xfer_clk_o),
    .out_off_o(out_off_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- pin monitor (sampled on falling system edge) --------
  logic [NBIT-1:0] rx = '0;
  int rises = 0, latches = 0, dones = 0;
  int lo_cnt = 0, hi_cnt = 0, xhi_cnt = 0, since_rise = 0;
  int clk_err = 0, data_err = 0, latch_err = 0, done_err = 0, idle_err = 0;
  logic p_sclk = 0, p_data = 0, p_xfer = 0, p_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      since_rise++;
      if (!busy_o && ser_clk_o) idle_err++;
      if (ser_clk_o && !p_sclk) begin
        rises++;
        since_rise = 0;
        rx = {rx[NBIT-2:0], ser_data_o};
        if (ser_data_o !== p_data) data_err++;
        if (lo_cnt != HALF) clk_err++;
        hi_cnt = 0;
      end
      if (!ser_clk_o && p_sclk) begin
        if (hi_cnt != HALF) clk_err++;
        lo_cnt = 0;
      end
      if (ser_data_o !== p_data && ser_clk_o) data_err++;
      if (busy_o && !ser_clk_o) lo_cnt++;
      if (!busy_o) lo_cnt = 0;
      if (ser_clk_o) hi_cnt++;
      if (xfer_clk_o && !p_xfer) begin
        latches++;
        if (since_rise < HALF) latch_err++;
        xhi_cnt = 0;
      end
      if (xfer_clk_o) begin
        xhi_cnt++;
        if (ser_clk_o) latch_err++;
      end
      if (!xfer_clk_o && p_xfer && xhi_cnt != HALF) latch_err++;
      if (done_o) begin
        dones++;
        if (p_done || busy_o || !p_xfer || xfer_clk_o) done_err++;
      end
      p_sclk = ser_clk_o; p_data = ser_data_o; p_xfer = xfer_clk_o; p_done = done_o;
    end
  end

  // ---------------- watchdog ---------------------------------------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [NBIT-1:0] exp_frame(input logic [9:0] a, input logic [9:0] b,
                                               input logic ha, input logic hb);
    return {hb, b, ha, a, 2'b00};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // ---------------- scenarios --------------------------------------------
  task automatic t_reset();
    rst = 1'b1; out_off_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_data_o == 0, "R1", "data in reset", ser_data_o, 0);
    chk(ser_clk_o == 0, "R1", "sclk in reset", ser_clk_o, 0);
    chk(xfer_clk_o == 0, "R1", "latch clk in reset", xfer_clk_o, 0);
    chk(busy_o == 0, "R1", "busy in reset", busy_o, 0);
    chk(done_o == 0, "R1", "done in reset", done_o, 0);
    chk(out_off_o == 1, "R1", "off pin in reset", out_off_o, 1);
    out_off_i = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(out_off_o == 1 && busy_o == 0, "R1", "state after reset",
        {out_off_o, busy_o}, 2'b10);
  endtask

  task automatic t_load(input logic [9:0] a, input logic [9:0] b,
                        input logic ha, input logic hb, input string tag);
    int r0, l0, d0, ce, de, le, oe, ie;
    bit seen;
    logic [NBIT-1:0] want;
    want = exp_frame(a, b, ha, hb);
    r0 = rises; l0 = latches; d0 = dones;
    ce = clk_err; de = data_err; le = latch_err; oe = done_err; ie = idle_err;
    chk(ser_clk_o == 0 && busy_o == 0, "R3", {tag, " idle before"}, {ser_clk_o, busy_o}, 0);
    @(negedge clk);
    dly_a_i = a; dly_b_i = b; hold_a_i = ha; hold_b_i = hb; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1, "R8", {tag, " busy after start"}, busy_o, 1);
    dly_a_i = ~a; dly_b_i = ~b; hold_a_i = ~ha; hold_b_i = ~hb;
    wait_done(seen);
    chk(seen, "R7", {tag, " done seen"}, seen, 1);
    chk(busy_o == 0, "R8", {tag, " busy low at done"}, busy_o, 0);
    chk(rx == want, "R2", {tag, " word"}, rx, want);
    chk(rises - r0 == NBIT, "R5", {tag, " rising edges"}, rises - r0, NBIT);
    chk(latches - l0 == 1, "R6", {tag, " latch pulses"}, latches - l0, 1);
    chk(latch_err == le, "R6", {tag, " latch timing"}, latch_err - le, 0);
    chk(clk_err == ce && idle_err == ie, "R3", {tag, " sclk phases"}, clk_err - ce, 0);
    chk(data_err == de, "R4", {tag, " data stability"}, data_err - de, 0);
    @(negedge clk);
    chk(done_o == 0 && dones - d0 == 1 && done_err == oe, "R7", {tag, " done one cycle"},
        dones - d0, 1);
  endtask

  task automatic t_busy_ignore();
    int l0;
    bit seen;
    logic [NBIT-1:0] want;
    want = exp_frame(10'h0F3, 10'h21C, 1'b1, 1'b0);
    l0 = latches;
    @(negedge clk);
    dly_a_i = 10'h0F3; dly_b_i = 10'h21C; hold_a_i = 1; hold_b_i = 0; start_i = 1;
    @(negedge clk) start_i = 0;
    repeat (61) @(negedge clk);
    dly_a_i = 10'h3FF; dly_b_i = 10'h000; hold_a_i = 0; hold_b_i = 1;
    start_i = 1;
    @(negedge clk) start_i = 0;
    chk(busy_o == 1, "R9", "busy kept on second start", busy_o, 1);
    wait_done(seen);
    chk(seen && rx == want, "R9", "word unchanged by second start", rx, want);
    repeat (3 * DIV) @(negedge clk);
    chk(busy_o == 0 && latches - l0 == 1, "R9", "no extra load", latches - l0, 1);
  endtask

  task automatic t_off();
    bit seen;
    @(negedge clk) out_off_i = 1'b0;
    @(negedge clk);
    chk(out_off_o == 0, "R10", "off follows low", out_off_o, 0);
    out_off_i = 1'b1;
    @(negedge clk);
    chk(out_off_o == 1, "R10", "off follows high", out_off_o, 1);
    pulse_start();
    repeat (30) @(negedge clk);
    out_off_i = 1'b0;
    @(negedge clk);
    chk(out_off_o == 0 && busy_o == 1, "R10", "off during load", {out_off_o, busy_o}, 2'b01);
    wait_done(seen);
    chk(seen && out_off_o == 0, "R10", "off kept through load end", out_off_o, 0);
  endtask

  initial begin
    t_reset();
    t_load(10'h000, 10'h000, 1'b0, 1'b0, "zeros");
    t_load(10'h3FF, 10'h3FF, 1'b1, 1'b1, "ones");
    t_load(10'h2AA, 10'h155, 1'b0, 1'b1, "alt1");
    t_load(10'h155, 10'h2AA, 1'b1, 1'b0, "alt2");
    t_load(10'h001, 10'h200, 1'b1, 1'b0, "walk");
    t_busy_ignore();
    t_off();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule